// File: doc/BRIEF.md
# Flash Bank Erase and Program Sequencer

This block drives a command-operated parallel NOR flash over a byte-wide bus to rewrite one bank of the array. The host picks a bank and starts an erase, a program of a full bank image, or both. When both are requested, the erase runs first and the image is then written into the freshly blanked bank. The sequencer issues the command bytes and polls the device status register until the device reports completion. It gives up after a bounded number of polls. It returns the device to array-read mode and, after an erase, reads every byte back to confirm the bank is blank.

Program data reaches the block as a byte stream with valid/ready handshaking, one byte per bank offset in ascending order. The host sees `busy` while a sequence runs. `done` goes high when the sequence ends and `err`/`errCode` give the outcome. Both hold until the next start.

Bank size (a power of two), bank-select width, clock rate in MHz (sets the one-microsecond setup-to-data gap) and the poll limit are parameters.

Top module: `flash_bank_seq`

## Requirements
- R1: An erase writes command 0x20 and, in the next cycle, command 0xD0, both to the bank base address (bank index times the bank size).
- R2: Each status poll writes 0x70 to the bank base, then reads one status byte; bit 7 set ends the poll. One poll is made per status read that shows bit 7 clear, plus the final one.
- R3: A completed poll whose status byte has any bit of mask 0x38 set ends the sequence with errCode 3.
- R4: Every poll, however it ends, is followed by command 0x50 and then command 0xFF to the bank base.
- R5: After an erase, every bank offset is read in ascending order. A byte other than 0xFF ends the sequence with errCode 4. A bank that reads all 0xFF gives errCode 0 when no program follows.
- R6: For each byte, programming writes 0x40 to that byte's address, then the data byte to the same address at least CLK_MHZ cycles later, and then starts a status poll.
- R7: POLL_LIMIT polls in a row without bit 7 end the sequence with errCode 1 during an erase and errCode 2 during a program.
- R8: `dataReady` is high only while the sequencer waits for the next program byte. Bytes are taken on `dataValid && dataReady` and written to offsets 0, 1, 2, … in order. A full program consumes exactly one bank of bytes.
- R9: Starting erase and program together erases, blank-checks, and then programs the same bank.
- R10: The first error ends the sequence: `busy` falls, `err` rises, `errCode` holds the nonzero cause, and no further flash strobe is issued.
- R11: Reset (asynchronous, active low) clears `busy`, `done`, `err`, `dataReady`, `flWe` and `flRe`, including in the middle of a sequence.
- R12: `done` and `errCode` hold from the end of a sequence until the next start, which clears `done` and `err` and raises `busy`. errCode 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startErase | input | 1 | Start an erase (sampled while idle) |
| startProgram | input | 1 | Start a program (with startErase: erase first) |
| bankSel | input | BANK_W | Bank index, latched at start |
| dataIn | input | 8 | Program byte from the host |
| dataValid | input | 1 | Program byte valid |
| dataReady | output | 1 | Sequencer takes the program byte this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence has ended |
| err | output | 1 | Last sequence ended in error |
| errCode | output | 3 | 0 ok, 1 erase timeout, 2 program timeout, 3 status error, 4 blank-check failure |
| flAddr | output | BANK_W+log2(BANK_BYTES) | Flash byte address |
| flWdata | output | 8 | Flash write data |
| flRdata | input | 8 | Flash read data, valid the cycle after flRe |
| flWe | output | 1 | Flash write strobe |
| flRe | output | 1 | Flash read strobe |

## Verification
The bench targets a device that never reports completion, a status byte with an error bit, and a bank where one byte stays programmed after the erase. It also covers a combined erase-then-program and a stalling byte stream. A sequencer that counted polls off by one would report a timeout at the wrong number of 0x70 writes. A sequencer that skipped cleanup on error would leave the last two writes different from 0x50, 0xFF. A sequencer that dropped the blank check would report success on the faulty bank. The bench timestamps each setup and data write, so a short setup-to-data gap is caught. It checks write addresses and the consumed-byte count, so a reordered or over-fetched stream is caught. A reset in the middle of a program checks that every strobe drops at once.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] CMD_ERASE_ARM  = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_BYTE_ARM   = 8'h40;
  localparam logic [7:0] CMD_STAT_CLEAR = 8'h50;
  localparam logic [7:0] CMD_STAT_QUERY = 8'h70;
  localparam logic [7:0] CMD_ARRAY_MODE = 8'hFF;
  localparam logic [7:0] STAT_READY_BIT = 8'h80;
  localparam logic [7:0] STAT_FAULT_MSK = 8'h38;
  localparam logic [7:0] BLANK_BYTE     = 8'hFF;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_ERASE_TMO = 3'd1,
    ERR_PROG_TMO  = 3'd2,
    ERR_STATUS    = 3'd3,
    ERR_BLANK     = 3'd4
  } errCodeT;

  // strobes from control to datapath
  typedef struct packed {
    logic bankLoad;
    logic ofsClr;
    logic ofsInc;
    logic pollClr;
    logic pollInc;
    logic gapClr;
    logic gapInc;
    logic byteLoad;
    logic flWr;
    logic flRd;
    logic atOffset;  // address = bank base + offset, else bank base
    logic cmdSel;    // write data = command byte, else host byte
  } seqStrobeT;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int OFS_W      = 13,
  parameter int POLL_LIMIT = 1000000,
  parameter int GAP_CYCLES = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobeT               stb,
  input  logic [7:0]              cmdByte,
  input  logic [BANK_W-1:0]       bankIn,
  input  logic [7:0]              dataIn,
  output logic [BANK_W+OFS_W-1:0] flAddr,
  output logic [7:0]              flWdata,
  output logic                    flWe,
  output logic                    flRe,
  output logic                    ofsLast,
  output logic                    pollLast,
  output logic                    gapDone
);

  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int GAP_W  = $clog2(GAP_CYCLES + 1);

  logic [BANK_W-1:0] bankReg;
  logic [OFS_W-1:0]  ofs;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [7:0]        byteReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankReg <= '0;
      ofs     <= '0;
      pollCnt <= '0;
      gapCnt  <= '0;
      byteReg <= '0;
    end else begin
      if (stb.bankLoad) bankReg <= bankIn;
      if (stb.ofsClr)       ofs <= '0;
      else if (stb.ofsInc)  ofs <= ofs + 1'b1;
      if (stb.pollClr)      pollCnt <= '0;
      else if (stb.pollInc) pollCnt <= pollCnt + 1'b1;
      if (stb.gapClr)       gapCnt <= '0;
      else if (stb.gapInc)  gapCnt <= gapCnt + 1'b1;
      if (stb.byteLoad) byteReg <= dataIn;
    end
  end

  assign ofsLast  = &ofs;
  assign pollLast = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign gapDone  = (gapCnt == GAP_W'(GAP_CYCLES - 1));

  assign flAddr  = {bankReg, (stb.atOffset ? ofs : {OFS_W{1'b0}})};
  assign flWdata = stb.cmdSel ? cmdByte : byteReg;
  assign flWe    = stb.flWr;
  assign flRe    = stb.flRd;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startErase,
  input  logic       startProgram,
  input  logic       dataValid,
  input  logic [7:0] flRdata,
  input  logic       ofsLast,
  input  logic       pollLast,
  input  logic       gapDone,
  output seqStrobeT  stb,
  output logic [7:0] cmdByte,
  output logic       dataReady,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [2:0] errCode
);

  typedef enum logic [3:0] {
    S_IDLE, S_EARM, S_EGO, S_PQUERY, S_PREAD, S_PEVAL, S_CLEAR, S_ARRAY,
    S_BREAD, S_BEVAL, S_FETCH, S_WARM, S_WGAP, S_WDATA
  } stateT;

  stateT   st;
  errCodeT errPend;
  logic    progPend, inProg;

  wire statReady = |(flRdata & STAT_READY_BIT);
  wire statFault = |(flRdata & STAT_FAULT_MSK);
  wire isBlank   = (flRdata == BLANK_BYTE);
  wire anyStart  = startErase | startProgram;

  always_comb begin
    stb       = '0;
    cmdByte   = 8'h00;
    dataReady = 1'b0;
    unique case (st)
      S_IDLE:   if (anyStart) begin stb.bankLoad = 1'b1; stb.ofsClr = 1'b1; end
      S_EARM:   begin stb.flWr = 1'b1; stb.cmdSel = 1'b1; cmdByte = CMD_ERASE_ARM; end
      S_EGO:    begin stb.flWr = 1'b1; stb.cmdSel = 1'b1; cmdByte = CMD_ERASE_GO;
                      stb.pollClr = 1'b1; end
      S_PQUERY: begin stb.flWr = 1'b1; stb.cmdSel = 1'b1; cmdByte = CMD_STAT_QUERY; end
      S_PREAD:  stb.flRd = 1'b1;
      S_PEVAL:  stb.pollInc = !statReady && !pollLast;
      S_CLEAR:  begin stb.flWr = 1'b1; stb.cmdSel = 1'b1; cmdByte = CMD_STAT_CLEAR; end
      S_ARRAY:  begin
        stb.flWr = 1'b1; stb.cmdSel = 1'b1; cmdByte = CMD_ARRAY_MODE;
        stb.ofsClr = (errPend == ERR_NONE) && !inProg;
        stb.ofsInc = (errPend == ERR_NONE) && inProg && !ofsLast;
      end
      S_BREAD:  begin stb.flRd = 1'b1; stb.atOffset = 1'b1; end
      S_BEVAL:  begin stb.ofsInc = isBlank && !ofsLast; stb.ofsClr = isBlank && ofsLast; end
      S_FETCH:  begin dataReady = 1'b1; stb.byteLoad = dataValid; end
      S_WARM:   begin stb.flWr = 1'b1; stb.cmdSel = 1'b1; stb.atOffset = 1'b1;
                      cmdByte = CMD_BYTE_ARM; stb.gapClr = 1'b1; end
      S_WGAP:   stb.gapInc = 1'b1;
      S_WDATA:  begin stb.flWr = 1'b1; stb.atOffset = 1'b1; stb.pollClr = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      errPend  <= ERR_NONE;
      progPend <= 1'b0;
      inProg   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      errCode  <= 3'd0;
    end else begin
      unique case (st)
        S_IDLE: if (anyStart) begin
          busy     <= 1'b1;
          done     <= 1'b0;
          err      <= 1'b0;
          errCode  <= 3'd0;
          errPend  <= ERR_NONE;
          progPend <= startProgram;
          inProg   <= !startErase;
          st       <= startErase ? S_EARM : S_FETCH;
        end
        S_EARM:   st <= S_EGO;
        S_EGO:    st <= S_PQUERY;
        S_PQUERY: st <= S_PREAD;
        S_PREAD:  st <= S_PEVAL;
        S_PEVAL:
          if (statReady) begin
            if (statFault) errPend <= ERR_STATUS;
            st <= S_CLEAR;
          end else if (pollLast) begin
            errPend <= inProg ? ERR_PROG_TMO : ERR_ERASE_TMO;
            st <= S_CLEAR;
          end else st <= S_PQUERY;
        S_CLEAR:  st <= S_ARRAY;
        S_ARRAY:
          if (errPend != ERR_NONE) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1; err <= 1'b1; errCode <= errPend;
          end else if (!inProg) st <= S_BREAD;
          else if (ofsLast) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1;
          end else st <= S_FETCH;
        S_BREAD:  st <= S_BEVAL;
        S_BEVAL:
          if (!isBlank) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1; err <= 1'b1; errCode <= ERR_BLANK;
          end else if (!ofsLast) st <= S_BREAD;
          else if (progPend) begin
            inProg <= 1'b1; st <= S_FETCH;
          end else begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1;
          end
        S_FETCH:  if (dataValid) st <= S_WARM;
        S_WARM:   st <= S_WGAP;
        S_WGAP:   if (gapDone) st <= S_WDATA;
        S_WDATA:  st <= S_PQUERY;
        default:  st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import flash_seq_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int BANK_W     = 2,
  parameter int CLK_MHZ    = 100,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  startErase,
  input  logic                                  startProgram,
  input  logic [BANK_W-1:0]                     bankSel,
  input  logic [7:0]                            dataIn,
  input  logic                                  dataValid,
  output logic                                  dataReady,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  err,
  output logic [2:0]                            errCode,
  output logic [BANK_W+$clog2(BANK_BYTES)-1:0]  flAddr,
  output logic [7:0]                            flWdata,
  input  logic [7:0]                            flRdata,
  output logic                                  flWe,
  output logic                                  flRe
);

  localparam int OFS_W      = $clog2(BANK_BYTES);
  localparam int GAP_CYCLES = (CLK_MHZ < 1) ? 1 : CLK_MHZ;  // one microsecond

  seqStrobeT  stb;
  logic [7:0] cmdByte;
  logic       ofsLast, pollLast, gapDone;

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startErase(startErase), .startProgram(startProgram),
    .dataValid(dataValid), .flRdata(flRdata), .ofsLast(ofsLast), .pollLast(pollLast),
    .gapDone(gapDone), .stb(stb), .cmdByte(cmdByte), .dataReady(dataReady),
    .busy(busy), .done(done), .err(err), .errCode(errCode)
  );

  flash_seq_dp #(
    .BANK_W(BANK_W), .OFS_W(OFS_W), .POLL_LIMIT(POLL_LIMIT), .GAP_CYCLES(GAP_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdByte(cmdByte), .bankIn(bankSel),
    .dataIn(dataIn), .flAddr(flAddr), .flWdata(flWdata), .flWe(flWe), .flRe(flRe),
    .ofsLast(ofsLast), .pollLast(pollLast), .gapDone(gapDone)
  );

endmodule

// File: rtl/flash_bank_seq_chk.sv
module flash_bank_seq_chk
  import flash_seq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [2:0] errCode,
  input logic       dataReady,
  input logic       flWe,
  input logic       flRe,
  input logic [7:0] flWdata,
  input seqStrobeT  stb
);

  p_confirm_follows_arm_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flWr && stb.cmdSel && flWdata == CMD_ERASE_ARM) |=> (flWe && flWdata == CMD_ERASE_GO));

  p_read_then_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    flRe |=> (!flWe && !flRe));

  p_array_follows_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flWr && stb.cmdSel && flWdata == CMD_STAT_CLEAR) |=> (flWe && flWdata == CMD_ARRAY_MODE));

  p_poll_after_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flWr && !stb.cmdSel) |=> (flWe && flWdata == CMD_STAT_QUERY));

  p_ready_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> (!flWe && !flRe));

  p_idle_no_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!flWe && !flRe && !dataReady));

  p_code_flag_agree_r10: assert property (@(posedge clk) disable iff (!rstN)
    err == (errCode != 3'd0));

  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind flash_bank_seq flash_bank_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err), .errCode(errCode),
  .dataReady(dataReady), .flWe(flWe), .flRe(flRe), .flWdata(flWdata), .stb(stb)
);

// File: tb/flash_bank_seq_bench.sv
module flash_bank_seq_bench;

  localparam int BB = 16, BW = 2, MHZ = 4, PL = 8, AW = BW + 4, NB = BB << BW;

  typedef struct packed {
    logic [1:0] op;      // bit0 erase, bit1 program
    logic [1:0] bank;
    logic [3:0] lat;     // status reads showing busy
    logic       stuck;
    logic [7:0] fault;   // status bits reported at completion
    logic [4:0] bad;     // offset left programmed by erase, 31 = none
    logic [2:0] exp;
  } vecT;

  localparam vecT VEC [8] = '{
    '{2'd1, 2'd1, 4'd2, 1'b0, 8'h00, 5'd31, 3'd0},
    '{2'd1, 2'd2, 4'd0, 1'b1, 8'h00, 5'd31, 3'd1},
    '{2'd1, 2'd0, 4'd1, 1'b0, 8'h10, 5'd31, 3'd3},
    '{2'd1, 2'd3, 4'd0, 1'b0, 8'h00, 5'd7,  3'd4},
    '{2'd2, 2'd1, 4'd1, 1'b0, 8'h00, 5'd31, 3'd0},
    '{2'd2, 2'd2, 4'd0, 1'b1, 8'h00, 5'd31, 3'd2},
    '{2'd3, 2'd3, 4'd0, 1'b0, 8'h00, 5'd31, 3'd0},
    '{2'd3, 2'd0, 4'd0, 1'b0, 8'h08, 5'd31, 3'd3}
  };
  localparam string TAG [8] = '{"R5", "R7", "R3", "R5", "R8", "R7", "R9", "R10"};

  logic clk = 0, rstN = 0, startErase = 0, startProgram = 0, dataValid = 0;
  logic [BW-1:0] bankSel = '0;
  logic [7:0] dataIn = '0, flRdata = '0, flWdata;
  logic dataReady, busy, done, err, flWe, flRe;
  logic [2:0] errCode;
  logic [AW-1:0] flAddr;

  flash_bank_seq #(.BANK_BYTES(BB), .BANK_W(BW), .CLK_MHZ(MHZ), .POLL_LIMIT(PL)) u_flash_bank_seq (
    .clk(clk), .rstN(rstN), .startErase(startErase), .startProgram(startProgram),
    .bankSel(bankSel), .dataIn(dataIn), .dataValid(dataValid), .dataReady(dataReady),
    .busy(busy), .done(done), .err(err), .errCode(errCode), .flAddr(flAddr),
    .flWdata(flWdata), .flRdata(flRdata), .flWe(flWe), .flRe(flRe));

  always #2 clk = ~clk;  // 250 MHz

  int nChk = 0, nErr = 0, cyc = 0;

  // flash stub
  logic [7:0] mem [NB];
  logic statMode = 0, armErase = 0, armByte = 0, stuck = 0;
  logic [7:0] fault = 0;
  logic [4:0] bad = 31;
  int lat = 0, busyLeft = 0, wn = 0;
  int logA [1024], logD [1024], logC [1024];
  bit logData [1024];

  always @(posedge clk) begin
    cyc++;
    if (flWe) begin
      logA[wn] = int'(flAddr); logD[wn] = int'(flWdata); logC[wn] = cyc; logData[wn] = armByte;
      if (wn < 1023) wn++;
      if (armByte) begin
        mem[flAddr] = mem[flAddr] & flWdata; busyLeft = lat; armByte = 0; statMode = 1;
      end else begin
        case (flWdata)
          8'h20: armErase = 1;
          8'hD0: if (armErase) begin
            for (int j = 0; j < BB; j++) mem[{flAddr[AW-1:4], 4'(j)}] = 8'hFF;
            if (bad != 31) mem[{flAddr[AW-1:4], bad[3:0]}] = 8'h00;
            busyLeft = lat; statMode = 1;
          end
          8'h40: armByte = 1;
          8'h70: statMode = 1;
          8'hFF: statMode = 0;
          default: ;
        endcase
        if (flWdata != 8'h20) armErase = 0;
      end
    end
    if (flRe) begin
      if (!statMode) flRdata <= mem[flAddr];
      else if (stuck) flRdata <= 8'h00;
      else if (busyLeft > 0) begin flRdata <= 8'h00; busyLeft--; end
      else flRdata <= 8'h80 | fault;
    end
  end

  // host byte stream
  logic feedOn = 0;
  logic [1:0] feedBank = 0;
  int feedIdx = 0;
  function automatic logic [7:0] pat(input logic [1:0] b, input int i);
    return 8'(i * 7 + int'(b) * 3 + 8'h11);
  endfunction
  always @(posedge clk) if (dataValid && dataReady) feedIdx++;
  always @(negedge clk) begin
    dataValid = feedOn && (cyc % 3 != 1);
    dataIn    = pat(feedBank, feedIdx);
  end

  always @(posedge clk) if (cyc > 150000) begin
    nErr++; nChk++;
    $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [1:0] bank);
    @(negedge clk);
    wn = 0; feedIdx = 0; feedBank = bank; feedOn = op[1];
    bankSel = bank; startErase = op[0]; startProgram = op[1];
    @(negedge clk);
    startErase = 0; startProgram = 0;
    for (int g = 0; g < 20000 && !done; g++) @(negedge clk);
    feedOn = 0;
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mem[i] = 8'hA5;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !flWe && !flRe && !dataReady, "R11", "reset outputs",
        {busy, done, err, flWe, flRe, dataReady}, 0);
    rstN = 1;

    for (int v = 0; v < 8; v++) begin
      automatic vecT t = VEC[v];
      automatic int base = int'(t.bank) * BB;
      automatic int n70 = 0, nData = 0, wEnd;
      for (int i = 0; i < NB; i++) mem[i] = 8'hA5;
      for (int i = 0; i < BB; i++) mem[base + i] = t.op[0] ? 8'h3C : 8'hFF;
      lat = int'(t.lat); stuck = t.stuck; fault = t.fault; bad = t.bad;
      busyLeft = 0; statMode = 0; armErase = 0; armByte = 0;
      runOp(t.op, t.bank);

      chk(errCode == t.exp, TAG[v], $sformatf("vec%0d errCode", v), int'(errCode), int'(t.exp));
      chk(done && !busy && (err == (t.exp != 0)), "R12", $sformatf("vec%0d done/busy/err", v),
          {done, busy, err}, {2'b10, t.exp != 0});
      if (t.op[0])
        chk(logA[0] == base && logD[0] == 'h20 && logA[1] == base && logD[1] == 'hD0 &&
            logC[1] == logC[0] + 1, "R1", $sformatf("vec%0d erase commands", v),
            logD[0] * 256 + logD[1], 'h20D0);
      if (t.exp != 4)
        chk(logD[wn-2] == 'h50 && logD[wn-1] == 'hFF && logA[wn-1] == base, "R4",
            $sformatf("vec%0d cleanup", v), logD[wn-2] * 256 + logD[wn-1], 'h50FF);
      for (int k = 0; k < wn; k++) begin
        if (!logData[k] && logD[k] == 'h70) n70++;
        if (logData[k]) begin
          chk(k > 0 && logD[k-1] == 'h40 && logA[k-1] == logA[k] && logC[k] - logC[k-1] >= MHZ,
              "R6", $sformatf("vec%0d setup gap", v), logC[k] - logC[k-1], MHZ);
          chk(logA[k] == base + nData, "R8", $sformatf("vec%0d byte address", v), logA[k], base + nData);
          nData++;
        end
      end
      if (t.exp == 1 || t.exp == 2)
        chk(n70 == PL, "R7", $sformatf("vec%0d polls before timeout", v), n70, PL);
      if (t.op == 2'd1 && t.exp == 0) begin
        chk(n70 == lat + 1, "R2", "poll count", n70, lat + 1);
        for (int i = 0; i < NB; i++)
          if (mem[i] != ((i / BB == int'(t.bank)) ? 8'hFF : 8'hA5))
            chk(0, "R5", $sformatf("erased image at %0d", i), int'(mem[i]), 0);
        chk(1, "R5", "erased image", 0, 0);
      end
      if (t.op[1] && t.exp == 0) begin
        chk(feedIdx == BB && nData == BB, "R8", $sformatf("vec%0d bytes consumed", v), feedIdx, BB);
        for (int i = 0; i < BB; i++)
          chk(mem[base + i] == pat(t.bank, i), t.op[0] ? "R9" : "R6",
              $sformatf("vec%0d byte %0d", v, i), int'(mem[base + i]), int'(pat(t.bank, i)));
      end
      if (t.exp != 0) begin
        wEnd = wn;
        repeat (20) @(negedge clk);
        chk(wn == wEnd && !busy && !dataReady, "R10", $sformatf("vec%0d no strobe after error", v), wn, wEnd);
      end
    end

    // R12: done holds, next start clears it
    repeat (10) @(negedge clk);
    chk(done && err && errCode == 3'd3, "R12", "outcome held while idle", {done, err, errCode}, 5'b11011);
    stuck = 1; fault = 0;
    @(negedge clk); bankSel = 2'd1; startErase = 1;
    @(negedge clk); startErase = 0;
    chk(busy && !done && !err && errCode == 0, "R12", "start clears outcome", {busy, done, err, errCode}, 5'b10000);
    for (int g = 0; g < 2000 && !done; g++) @(negedge clk);
    chk(errCode == 3'd1, "R7", "erase timeout code", int'(errCode), 1);

    // R11: reset in mid-program
    stuck = 0; lat = 3;
    @(negedge clk); feedOn = 1; feedIdx = 0; bankSel = 2'd2; startProgram = 1;
    @(negedge clk); startProgram = 0;
    repeat (30) @(negedge clk);
    rstN = 0;
    #1;
    chk(!busy && !done && !err && !flWe && !flRe && !dataReady, "R11", "mid-run reset",
        {busy, done, err, flWe, flRe, dataReady}, 0);
    feedOn = 0;
    @(negedge clk); rstN = 1;
    repeat (5) @(negedge clk);
    chk(!busy && !flWe && !flRe, "R11", "idle after reset", {busy, flWe, flRe}, 0);

    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule